// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block divides a prescaled VCO edge stream and steers an external two-ratio prescaler. Each prescaler output edge reaches the block as a one-clock enable pulse, `vco_tick`. The block holds two down-counters: a main counter loaded with N and a swallow counter loaded with A. Both counters step on every tick. While the swallow counter is non-zero, the modulus output stays low, which selects the prescaler's larger ratio. Once the swallow counter reaches zero, the output goes high and the prescaler switches to its smaller ratio for the rest of the cycle. When the main counter completes, the block emits a one-clock divided-frequency pulse for a phase detector, reloads both counters and starts again. With a prescaler of ratio P+1 / P, the VCO is divided by N·P + A.

N and A come from a programming latch outside the block. The block samples them only at a reload, so a write that arrives mid-cycle never disturbs the cycle in progress. If A is larger than the effective N, the block raises an error flag and clamps A to N. If N is below the legal minimum, it is raised to 3.

Top module: `swallow_ctl`

## Requirements
- R1: During and right after synchronous reset (rst_n low), div_pulse is 0. The counters hold the current programmed values, so mod_ctl is 0 when the effective A is non-zero and 1 when it is zero.
- R2: In a cycle with effective A > 0, mod_ctl is 0 for the first A ticks of the cycle. It falls only on the clock edge that reloads the counters.
- R3: After the first A ticks, mod_ctl is 1 for the remaining N−A ticks of the cycle.
- R4: The clock after the Nth tick of a cycle, div_pulse is 1 for exactly one clock. The next cycle then starts with both counters reloaded.
- R5: With A = 0, mod_ctl is 1 for every tick of the cycle.
- R6: A change to n_prog or a_prog in the middle of a cycle has no effect until the next reload.
- R7: When a_prog exceeds the effective N at a reload, cfg_err is 1 for that cycle and A is clamped to N, so mod_ctl is 0 for all N ticks. cfg_err changes only at a reload.
- R8: A programmed N below 3 is treated as 3.
- R9: With a prescaler dividing by P+1 while mod_ctl is 0 and by P while it is 1, the VCO edges per div_pulse total N·P + A, for A ≤ N.
- R10: With no tick, mod_ctl holds its value, however long the gap between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One-clock pulse per prescaler output edge |
| n_prog | input | NW (10) | Programmed main count N |
| a_prog | input | AW (7) | Programmed swallow count A |
| mod_ctl | output | 1 | Prescaler modulus select: 0 = P+1, 1 = P |
| div_pulse | output | 1 | One-clock pulse at the end of each count cycle |
| cfg_err | output | 1 | A exceeded N for the cycle in progress |

## Verification
The hardest case to reach is a write that lands mid-cycle. It has to stay invisible until the reload, and then it has to take effect exactly at the reload, even when the new values also trigger clamping or the N minimum. The stimulus changes n_prog and a_prog between individual ticks at several points within a cycle, including during the last tick before the terminal count. The bench's model reads the inputs only at its own reload, so any early or late pick-up shows up as a wrong mod_ctl level or a misplaced div_pulse. Long idle gaps between ticks are mixed in to show that only ticks move the counters.

// File: rtl/swallow_ctl.sv
module swallow_ctl #(
  parameter int NW = 10,
  parameter int AW = 7,
  localparam int NMIN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_tick,
  input  logic [NW-1:0] n_prog,
  input  logic [AW-1:0] a_prog,
  output logic          mod_ctl,
  output logic          div_pulse,
  output logic          cfg_err
);

  logic [NW-1:0] n_cnt;
  logic [AW-1:0] a_cnt;
  logic [NW-1:0] n_eff;
  logic [NW-1:0] a_wide;
  logic          a_over;
  logic [AW-1:0] a_eff;
  logic          terminal;

  assign n_eff    = (n_prog < NW'(NMIN)) ? NW'(NMIN) : n_prog;
  assign a_wide   = NW'(a_prog);
  assign a_over   = a_wide > n_eff;
  assign a_eff    = a_over ? n_eff[AW-1:0] : a_prog;
  assign terminal = vco_tick && (n_cnt == NW'(1));
  assign mod_ctl  = (a_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || terminal) begin
      n_cnt   <= n_eff;
      a_cnt   <= a_eff;
      cfg_err <= a_over;
    end else if (vco_tick) begin
      n_cnt <= n_cnt - NW'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= terminal;
  end

  assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_tick |=> $stable(mod_ctl));
  assert_pulse_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  assert_pulse_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(vco_tick));
  assert_mod_falls_at_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctl) |-> div_pulse);
  assert_err_changes_at_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> div_pulse);
  assert_a_within_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
    NW'(a_cnt) <= n_cnt);
  assert_n_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    n_cnt != '0);

endmodule

// File: tb/swallow_ctl_tb_top.sv
module swallow_ctl_tb_top;
  localparam int NW = 10;
  localparam int AW = 7;
  localparam int P  = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic vco_tick = 0;
  logic [NW-1:0] n_prog = 10;
  logic [AW-1:0] a_prog = 3;
  logic mod_ctl, div_pulse, cfg_err;

  swallow_ctl #(.NW(NW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .n_prog(n_prog), .a_prog(a_prog),
    .mod_ctl(mod_ctl), .div_pulse(div_pulse), .cfg_err(cfg_err));

  always #5 clk = ~clk;

  typedef struct {
    logic  mod;
    logic  pulse;
    logic  err;
    int    total;
    string tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  string ctx = "";

  int pos, cur_n, cur_a, cur_tot;
  logic cur_err;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_load();
    cur_n = (n_prog < 3) ? 3 : int'(n_prog);
    cur_err = int'(a_prog) > cur_n;
    cur_a = cur_err ? cur_n : int'(a_prog);
    cur_tot = cur_err ? -1 : cur_n * P + cur_a;
    pos = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_load();
    #1;
    check("R1 pulse", div_pulse, 0);
    check("R1 mod", mod_ctl, (cur_a == 0) ? 1 : 0);
    check("R1 err", cfg_err, cur_err);
  endtask

  task automatic do_tick(int gap);
    item_t it;
    it.mod = (pos >= cur_a);
    if (ctx != "") it.tag = ctx;
    else if (cur_a == 0) it.tag = "R5";
    else it.tag = it.mod ? "R3" : "R2";
    it.total = cur_tot;
    pos++;
    it.pulse = (pos == cur_n);
    if (it.pulse) model_load();
    it.err = cur_err;
    q.push_back(it);
    @(negedge clk) vco_tick = 1;
    @(negedge clk) vco_tick = 0;
    repeat (gap < 1 ? 1 : gap) @(negedge clk);
  endtask

  task automatic ticks(int k, int gap);
    for (int i = 0; i < k; i++) do_tick(gap);
  endtask

  initial begin : monitor
    item_t it;
    int vco_cnt = 0;
    forever begin
      @(negedge clk); #1;
      if (vco_tick && q.size() > 0) begin
        it = q.pop_front();
        vco_cnt += mod_ctl ? P : P + 1;
        check({it.tag, " mod"}, mod_ctl, it.mod);
        @(negedge clk); #1;
        check("R4 pulse", div_pulse, it.pulse);
        check("R7 err", cfg_err, it.err);
        if (it.pulse) begin
          if (it.total >= 0) check("R9 total", vco_cnt, it.total);
          vco_cnt = 0;
        end
      end else if (!rst_n) vco_cnt = 0;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_prog = 10; a_prog = 3;
    do_reset();
    ticks(20, 1);
    // R5: A = 0, mod high all cycle
    n_prog = 4; a_prog = 0;
    ticks(10, 2);
    // R6: mid-cycle reprogramming
    n_prog = 12; a_prog = 5;
    ticks(4, 1);
    ctx = "R6";
    n_prog = 6; a_prog = 2;
    ticks(5, 1);
    n_prog = 7; a_prog = 4;
    ticks(3, 1);
    ctx = "";
    ticks(14, 1);
    // R7: A greater than N
    n_prog = 5; a_prog = 9;
    ticks(12, 1);
    // R8: N below minimum
    n_prog = 1; a_prog = 1;
    ticks(9, 1);
    n_prog = 0; a_prog = 0;
    ticks(6, 1);
    // R10: long idle gaps
    n_prog = 9; a_prog = 4;
    ctx = "R10";
    ticks(20, 37);
    ctx = "";
    // R1: reset with A = 0 and with A > N
    n_prog = 8; a_prog = 0;
    do_reset();
    ticks(16, 1);
    n_prog = 3; a_prog = 100;
    do_reset();
    ticks(6, 1);
    // large N, R9
    n_prog = 1023; a_prog = 127;
    do_reset();
    ticks(1023, 1);
    repeat (4) @(negedge clk);
    check("R4 queue drained", q.size(), 0);
    finish_run();
  end
endmodule